// File: doc/BRIEF.md
# MDIO Management Frame Master

This block acts as the station-management master on a two-wire PHY management bus. It builds clause 22 management frames for register reads and writes. It produces the management clock (MDC) from the system clock and drives the data line (MDIO) through a separate output value and output enable, so that a pad-level tristate buffer can be placed outside. Every frame starts with a run of ones that synchronises the PHY. A command field follows. On a write the command is followed by the data. On a read the bus is released, and the PHY's turnaround and data bits are sampled.

A host hands over one request at a time on a valid/ready request port. The request carries the read/write flag, the 5-bit PHY address, a wide register-address field and the write data. A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. While a request is not accepted, the host must hold `req_valid`, and the block simply does not take it. The response side has no back-pressure. `done` is a one-cycle pulse, and `rd_data` is held until the next read completes. A register address above 31 is rejected locally and completes at once, without any bus activity.

The MDC half-period is derived from two parameters: the system clock frequency and the highest allowed MDC frequency. The default values give a 2.5 MHz MDC from a 250 MHz clock.

Top module: `mdio_master`

## Requirements
- R1: Each MDC high phase and each MDC low phase inside a frame lasts exactly H system clocks. H = max(3, ceil(CLK_HZ / (2 × MDC_MAX_HZ))). MDC is low whenever the block is idle.
- R2: Every frame begins with 33 MDC cycles during which MDIO is driven (`mdio_oe`=1) with value 1.
- R3: MDIO output value and enable change only while MDC is low. Both stay stable for the whole high phase, so the PHY latches them on the MDC rising edge.
- R4: After the 33 ones, a read drives 16 bits MSB first: `11`, `01`, `10`, then PHY address[4:0], then register address[4:0]. It then releases MDIO (`mdio_oe`=0) for 19 MDC cycles. A read frame has 68 MDC rising edges in total.
- R5: On a read, MDIO passes through a two-flop synchronizer and is sampled at each MDC rising edge of the released part. Samples 1, 2 and 19 are discarded. Samples 3 to 18 form `rd_data` with sample 3 as bit 15.
- R6: After the 33 ones, a write drives a 32-bit word MSB first: bits 31:28 = `0101`, bits 27:23 = PHY address, bits 22:18 = register address, bits 17:16 = `10`, bits 15:0 = write data. It then releases MDIO for 2 more MDC cycles. A write frame has 67 MDC rising edges.
- R7: If any bit of `req_reg` above bit 4 is set, the request causes no MDC edge and never drives MDIO. `done` rises in the cycle after acceptance. For a read, `rd_data` becomes 16'hFFFF. For a write, `rd_data` is unchanged.
- R8: `req_ready` is low while `busy` is high and in the cycle when `done` is high. A request offered in those cycles is ignored.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle. For a frame with N MDC cycles, `done` is visible 2·H·N+1 clocks after the request is accepted: 681 clocks for a read and 671 clocks for a write when H=5.
- R10: After reset, `mdc`=0, `mdio_oe`=0, `busy`=0, `done`=0, `rd_data`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_W | Register address; values above 31 are rejected |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The bench counts clock cycles from the acceptance edge. It expects `done` exactly 2·H·N+1 cycles later: N is 68 for reads and 67 for writes, and 1 cycle for a rejected address. The bench asserts a request at a falling clock edge and samples every output at falling edges, one half-cycle away from the edge that updates the registers. A responder in the bench puts each read bit on `mdio_i` at the MDC falling edge before the rising edge that samples it, which leaves H−2 clocks of margin after the synchronizer. Frame content, MDC edge counts and phase lengths are gathered by a monitor that runs on falling clock edges. After `done`, the bench compares them against values built from the request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 33;
  localparam int RD_CMD_LEN = 16;
  localparam int WR_CMD_LEN = 32;
  localparam int RD_TAIL    = 19;
  localparam int WR_TAIL    = 2;
  localparam int SR_W       = PRE_BITS + WR_CMD_LEN;
  localparam int CNT_W      = $clog2(SR_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DRIVE, ST_RELEASE} mdio_state_e;

  // Left-justified driven part of a frame: preamble then command
  function automatic logic [SR_W-1:0] build_frame(input logic wr, input logic [4:0] phy,
                                                  input logic [4:0] rg, input logic [15:0] wd);
    if (wr) build_frame = {{PRE_BITS{1'b1}}, 4'b0101, phy, rg, 2'b10, wd};
    else    build_frame = {{PRE_BITS{1'b1}}, 6'b110110, phy, rg, 16'h0000};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic bit_rise,
  output logic bit_end
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 2;
  localparam int RW = $clog2(HALF + 1) + 1;

  logic [CW-1:0] cnt;
  logic          phase;
  logic          last;

  assign last     = (cnt == CW'(HALF - 1));
  assign bit_rise = en && last && !phase;
  assign bit_end  = en && last && phase;
  assign mdc      = phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (last) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // Checker: length of the phase MDC just left
  logic          mdc_d;
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_d   <= 1'b0;
      run_len <= RW'(HALF);
    end else begin
      mdc_d <= mdc;
      if (mdc != mdc_d)               run_len <= RW'(1);
      else if (run_len < RW'(HALF))   run_len <= run_len + 1'b1;
    end
  end

  // R1
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_d) |-> (run_len >= RW'(HALF)));
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mdc);
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [4:0]       req_phy,
  input  logic [REG_W-1:0] req_reg,
  input  logic [15:0]      req_wdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  input  logic             bit_rise,
  input  logic             bit_end,
  output logic             clk_en,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_in_s
);
  mdio_state_e      state;
  logic [SR_W-1:0]  tx_sr;
  logic [CNT_W-1:0] bits_left;
  logic             is_rd;
  logic [15:0]      rx_sr;
  logic             done_q;
  logic [15:0]      rd_q;
  logic             reg_bad;
  logic             accept;

  generate
    if (REG_W > 5) begin : g_chk
      assign reg_bad = |req_reg[REG_W-1:5];
    end else begin : g_nochk
      assign reg_bad = 1'b0;
    end
  endgenerate

  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE) && !done_q;
  assign accept    = req_valid && req_ready;
  assign clk_en    = busy;
  assign mdio_oe   = (state == ST_DRIVE);
  assign mdio_o    = mdio_oe & tx_sr[SR_W-1];
  assign done      = done_q;
  assign rd_data   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tx_sr     <= '0;
      bits_left <= '0;
      is_rd     <= 1'b0;
      rx_sr     <= '0;
      done_q    <= 1'b0;
      rd_q      <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (reg_bad) begin
              done_q <= 1'b1;
              if (!req_write) rd_q <= 16'hFFFF;
            end else begin
              tx_sr     <= build_frame(req_write, req_phy, req_reg[4:0], req_wdata);
              bits_left <= req_write ? CNT_W'(PRE_BITS + WR_CMD_LEN)
                                     : CNT_W'(PRE_BITS + RD_CMD_LEN);
              is_rd     <= !req_write;
              state     <= ST_DRIVE;
            end
          end
        end
        ST_DRIVE: begin
          if (bit_end) begin
            tx_sr <= tx_sr << 1;
            if (bits_left == CNT_W'(1)) begin
              state     <= ST_RELEASE;
              bits_left <= is_rd ? CNT_W'(RD_TAIL) : CNT_W'(WR_TAIL);
            end else begin
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        ST_RELEASE: begin
          // the final sample of a read is never kept
          if (bit_rise && is_rd && bits_left != CNT_W'(1))
            rx_sr <= {rx_sr[14:0], mdio_in_s};
          if (bit_end) begin
            if (bits_left == CNT_W'(1)) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
              if (is_rd) rd_q <= rx_sr;
            end else begin
              bits_left <= bits_left - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && reg_bad) |=> (done && !busy));
  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_HZ     = 250_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int REG_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [4:0]       req_phy,
  input  logic [REG_W-1:0] req_reg,
  input  logic [15:0]      req_wdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int MIN_HALF = (CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
  localparam int HALF     = (MIN_HALF < 3) ? 3 : MIN_HALF;

  logic clk_en, bit_rise, bit_end, mdio_in_s;

  mdio_mdc_gen #(.HALF(HALF)) u_mdc (
    .clk(clk), .rst_n(rst_n), .en(clk_en),
    .mdc(mdc), .bit_rise(bit_rise), .bit_end(bit_end)
  );

  mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mdio_i), .q(mdio_in_s)
  );

  mdio_frame_eng #(.REG_W(REG_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .bit_rise(bit_rise), .bit_end(bit_end), .clk_en(clk_en),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_in_s(mdio_in_s)
  );

  // R3
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int H = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0;
  logic [7:0] req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  always #2 clk = ~clk;

  mdio_master #(.CLK_HZ(250_000_000), .MDC_MAX_HZ(25_000_000), .REG_W(8)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // PHY responder settings (written by tasks only)
  logic [15:0] phy_rdata = '0;
  logic        tail_bit = 1'b1;
  logic        cur_rd = 1'b0;

  // Monitor state (written by monitor only)
  logic         mdc_prev = 1'b0, o_prev = 1'b0, oe_prev = 1'b0;
  int           rises = 0, drv_cnt = 0, fr_cnt = 0;
  logic [127:0] drv_bits = '0;
  int           hi_len = 0, lo_len = 0;
  int           hi_min = 9999, hi_max = 0, lo_min = 9999, lo_max = 0;
  int           hold_viol = 0, idle_hi = 0, done_run = 0, done_max = 0;
  bit           lo_on = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc && !mdc_prev) begin
        rises <= rises + 1;
        fr_cnt <= fr_cnt + 1;
        hi_len <= 1;
        if (lo_on) begin
          if (lo_len < lo_min) lo_min <= lo_len;
          if (lo_len > lo_max) lo_max <= lo_len;
        end
        if (mdio_oe) begin
          drv_bits <= {drv_bits[126:0], mdio_o};
          drv_cnt  <= drv_cnt + 1;
        end
      end else if (mdc) begin
        hi_len <= hi_len + 1;
        if (mdio_o != o_prev || mdio_oe != oe_prev) hold_viol <= hold_viol + 1;
      end else if (mdc_prev) begin
        if (hi_len < hi_min) hi_min <= hi_len;
        if (hi_len > hi_max) hi_max <= hi_len;
        lo_len <= 1;
        lo_on  <= busy;
        // responder: present the next released-bus bit
        if (busy && cur_rd && fr_cnt >= 49 && fr_cnt <= 67) begin
          if (fr_cnt == 49)      mdio_i <= 1'b1;
          else if (fr_cnt == 50) mdio_i <= 1'b0;
          else if (fr_cnt == 67) mdio_i <= tail_bit;
          else                   mdio_i <= phy_rdata[66 - fr_cnt];
        end else begin
          mdio_i <= 1'b1;
        end
      end else begin
        lo_len <= lo_len + 1;
      end
      if (!busy) begin
        fr_cnt <= 0;
        lo_on  <= 0;
        if (mdc) idle_hi <= idle_hi + 1;
      end
      if (done) begin
        done_run <= done_run + 1;
        if (done_run + 1 > done_max) done_max <= done_run + 1;
      end else done_run <= 0;
    end
    mdc_prev <= mdc;
    o_prev   <= mdio_o;
    oe_prev  <= mdio_oe;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic wr, input logic [4:0] phy, input logic [7:0] rg,
                        input logic [15:0] wd, output int lat);
    @(negedge clk);
    req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 3000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic test_reset;
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 mdc/oe after reset", {mdc, mdio_oe}, 0);
    chk(busy == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R10 busy/done/ready after reset",
        {busy, done, req_ready}, 1);
    chk(rd_data == 16'h0, "R10 rd_data after reset", rd_data, 0);
  endtask

  task automatic test_read(input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] val, input logic tail);
    int lat, r0, d0;
    logic [48:0] exp;
    phy_rdata = val; tail_bit = tail; cur_rd = 1'b1;
    r0 = rises; d0 = drv_cnt;
    launch(1'b0, phy, {3'b000, rg}, 16'h0, lat);
    exp = {{33{1'b1}}, 6'b110110, phy, rg};
    chk(lat == 68 * 2 * H + 1, "R9 read done latency", lat, 68 * 2 * H + 1);
    chk(busy == 1'b0 && req_ready == 1'b0, "R8 ready low in done cycle", {busy, req_ready}, 0);
    chk(rd_data == val, "R5 read data", rd_data, val);
    chk(rises - r0 == 68, "R4 read MDC edges", rises - r0, 68);
    chk(drv_cnt - d0 == 49, "R4 read driven bits", drv_cnt - d0, 49);
    chk(drv_bits[48:16] == {33{1'b1}}, "R2 read preamble", drv_bits[48:16], 33'h1FFFFFFFF);
    chk(drv_bits[48:0] == exp, "R4 read command", drv_bits[48:0], exp);
    @(negedge clk);
    chk(done == 1'b0, "R9 done width", done, 0);
    cur_rd = 1'b0;
  endtask

  task automatic test_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
    int lat, r0, d0;
    logic [15:0] rd0;
    logic [64:0] exp;
    r0 = rises; d0 = drv_cnt; rd0 = rd_data;
    launch(1'b1, phy, {3'b000, rg}, val, lat);
    exp = {{33{1'b1}}, 4'b0101, phy, rg, 2'b10, val};
    chk(lat == 67 * 2 * H + 1, "R9 write done latency", lat, 67 * 2 * H + 1);
    chk(rises - r0 == 67, "R6 write MDC edges", rises - r0, 67);
    chk(drv_cnt - d0 == 65, "R6 write driven bits", drv_cnt - d0, 65);
    chk(drv_bits[64:32] == {33{1'b1}}, "R2 write preamble", drv_bits[64:32], 33'h1FFFFFFFF);
    chk(drv_bits[31:0] == exp[31:0], "R6 write word", drv_bits[31:0], exp[31:0]);
    chk(rd_data == rd0, "R6 rd_data kept on write", rd_data, rd0);
  endtask

  task automatic test_bad(input logic wr, input logic [7:0] rg);
    int lat, r0, d0;
    logic [15:0] rd0, exp;
    r0 = rises; d0 = drv_cnt; rd0 = rd_data;
    rd0 = rd_data;
    launch(wr, 5'd3, rg, 16'h1234, lat);
    exp = wr ? rd0 : 16'hFFFF;
    chk(lat == 1, "R7 immediate done", lat, 1);
    chk(busy == 1'b0, "R7 never busy", busy, 0);
    chk(rd_data == exp, "R7 rd_data", rd_data, exp);
    repeat (3 * H) @(negedge clk);
    chk(rises == r0 && drv_cnt == d0, "R7 no bus activity", rises - r0 + drv_cnt - d0, 0);
  endtask

  task automatic test_busy_ignore;
    int r0, n_done, d0;
    r0 = rises; d0 = drv_cnt; n_done = 0;
    phy_rdata = 16'h3C5A; tail_bit = 1'b0; cur_rd = 1'b1;
    @(negedge clk);
    req_write = 1'b0; req_phy = 5'd9; req_reg = 8'd17; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (100) @(negedge clk);
    chk(busy == 1'b1 && req_ready == 1'b0, "R8 ready low while busy", {busy, req_ready}, 2);
    req_write = 1'b1; req_phy = 5'd2; req_reg = 8'd4; req_wdata = 16'hFFFF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (done) n_done++;
    end
    chk(n_done == 1, "R8 one completion only", n_done, 1);
    chk(rises - r0 == 68, "R8 ignored request adds no frame", rises - r0, 68);
    chk(drv_cnt - d0 == 49, "R8 ignored write not driven", drv_cnt - d0, 49);
    chk(rd_data == 16'h3C5A, "R5 read data after ignored request", rd_data, 16'h3C5A);
    cur_rd = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_read(5'd5, 5'd2, 16'hA5C3, 1'b0);
    test_read(5'd31, 5'd31, 16'h0001, 1'b1);
    test_write(5'd1, 5'd4, 16'h01E1);
    test_write(5'd26, 5'd0, 16'hFFFF);
    test_bad(1'b0, 8'h20);
    test_bad(1'b1, 8'h45);
    test_busy_ignore();
    chk(hi_min == H && hi_max == H, "R1 MDC high length", hi_max, H);
    chk(lo_min == H && lo_max == H, "R1 MDC low length", lo_max, H);
    chk(idle_hi == 0, "R1 MDC low when idle", idle_hi, 0);
    chk(hold_viol == 0, "R3 MDIO stable while MDC high", hold_viol, 0);
    chk(done_max == 1, "R9 done one cycle", done_max, 1);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule